// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns a virtual address into a physical address by following a tree of translation tables that lives in ordinary memory. A request carries the virtual address, the kind of access (load, store or instruction fetch), whether the access comes from user mode, and whether the tree has four or five levels. The root table's frame number comes from a control-register input. The block reads one 8-byte entry per level through a single memory port. When an entry has changed, it writes the entry back with its accessed bit set, and on a permitted store it also sets the dirty bit in the leaf entry.

Only one walk is active at a time, and `busy_o` holds off further requests. Each walk ends with a one-cycle response. That response holds either the physical address and its effective permissions, or a fault code together with the tree level at which the walk stopped. Virtual addresses that are not correctly sign-extended fault at once, without any memory traffic. Pages are 4 KiB; large pages and translation caching are not part of this block.

Top module: `ptw_top`

## Requirements
- R1: A successful walk returns `rsp_pa_o` = {leaf entry bits 51..12, VA bits 11..0}, with fault code 0 and `rsp_level_o` = 1.
- R2: Entry layout: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bit 63 no-execute, bits 51..12 frame number. In four-level mode the walk starts at level 4 with table frame `root_pfn_i` and moves down to level 1. At level L it reads byte address frame*4096 + 8*VA[12+9(L-1) +: 9]. The next table's frame is taken from the entry just read.
- R3: In five-level mode the walk begins at level 5, indexed by VA bits 56..48, and then continues exactly as in four-level mode.
- R4: An entry with present clear ends the walk with fault code 1 and reports that entry's level. No further entries are read. On any fault, `rsp_pa_o` and `rsp_perm_o` are zero.
- R5: Permissions combine along the path: writable and user are ANDed, no-execute is ORed. At the leaf, code 2 (protection) is raised for any of these: a store (`req_acc_i`=1) without writable, a user access without user, or a fetch (`req_acc_i`=2) with no-execute. Code 0 in `req_acc_i` is a load. On success `rsp_perm_o` = {nx, user, writable}.
- R6: A present entry is written back at the same address, right after it is read, only if the update changes it. The update sets the accessed bit, and also sets the dirty bit in the leaf entry on a store with no protection fault.
- R7: If the VA bits above bit 47 (four-level) or bit 56 (five-level) differ from that bit, the response is fault code 3 at the top level. It arrives in the cycle after acceptance, and no memory access is made.
- R8: A request is accepted only while `busy_o` is low. `busy_o` stays high from the cycle after acceptance through the response cycle, and requests seen while it is high are ignored. `rsp_valid_o` is a one-cycle pulse. `mem_req_o` and its address stay stable until `mem_ack_i`.
- R9: After reset, `busy_o`, `mem_req_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_va_i | input | 64 | Virtual address |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user_i | input | 1 | Access made from user mode |
| five_lvl_i | input | 1 | Select five-level tree |
| root_pfn_i | input | 40 | Root table frame number |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is an entry write-back |
| mem_addr_o | output | 52 | Entry byte address |
| mem_wdata_o | output | 64 | Updated entry |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_rdata_i | input | 64 | Entry read data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_pa_o | output | 52 | Physical address |
| rsp_fault_o | output | 2 | 0 none, 1 not present, 2 protection, 3 non-canonical |
| rsp_level_o | output | 3 | Level where the walk ended |
| rsp_perm_o | output | 3 | {nx, user, writable} |

## Verification
A wrong level counter or a stale table frame shows up on the very next memory request as a wrong entry address. The reference model checks every access as it is acknowledged, so such errors are caught within one memory latency. A badly merged permission or a missed update shows up either as a wrong or missing write-back data word during the walk, or as a wrong fault code and permission field in the response pulse. Fault-path errors leave traces at the ports: extra reads after a not-present entry, or any access at all after a non-canonical address. Either is reported as an unexpected access.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int ENT_W   = 64;
  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USER  = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;
  localparam int B_NX    = 63;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NP    = 2'd1,
    FLT_PROT  = 2'd2,
    FLT_CANON = 2'd3
  } flt_e;

  typedef struct packed {
    logic nx;
    logic user;
    logic wr;
  } perm_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD,
    S_WB,
    S_RSP
  } st_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int VA_W  = 64,
  parameter int OFF_W = 12,
  parameter int IDX_W = 9,
  parameter int LVL_N = 5,
  parameter int LVL_W = 3
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] slice [LVL_N];

  for (genvar g = 0; g < LVL_N; g++) begin : g_slice
    assign slice[g] = va_i[OFF_W + IDX_W*g +: IDX_W];
  end

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < LVL_N; k++) begin
      if (lvl_i == LVL_W'(k + 1)) idx_o = slice[k];
    end
  end
endmodule

// File: rtl/ptw_canon.sv
module ptw_canon #(
  parameter int VA_W  = 64,
  parameter int OFF_W = 12,
  parameter int IDX_W = 9
) (
  input  logic [VA_W-1:0] va_i,
  input  logic            five_i,
  output logic            ok_o
);
  logic ok_v [2];

  // g=0: four-level space, g=1: five-level space
  for (genvar g = 0; g < 2; g++) begin : g_mode
    localparam int TOP = OFF_W + IDX_W*(4 + g) - 1;
    logic [VA_W-1-TOP:0] hi;
    assign hi      = va_i[VA_W-1:TOP];
    assign ok_v[g] = (&hi) | ~(|hi);
  end

  assign ok_o = five_i ? ok_v[1] : ok_v[0];
endmodule

// File: rtl/ptw_eval.sv
module ptw_eval
  import ptw_pkg::*;
(
  input  logic [ENT_W-1:0] entry_i,
  input  logic             leaf_i,
  input  acc_e             acc_i,
  input  logic             user_i,
  input  perm_t            perm_i,
  output logic             present_o,
  output perm_t            perm_o,
  output logic             prot_o,
  output logic [ENT_W-1:0] upd_o,
  output logic             wb_o
);
  logic set_dirty;

  assign present_o   = entry_i[B_PRES];
  assign perm_o.wr   = perm_i.wr   & entry_i[B_WR];
  assign perm_o.user = perm_i.user & entry_i[B_USER];
  assign perm_o.nx   = perm_i.nx   | entry_i[B_NX];

  assign prot_o = leaf_i & (((acc_i == ACC_STORE) & ~perm_o.wr) |
                            (user_i & ~perm_o.user) |
                            ((acc_i == ACC_FETCH) & perm_o.nx));

  assign set_dirty = leaf_i & (acc_i == ACC_STORE) & ~prot_o;

  always_comb begin
    upd_o = entry_i;
    upd_o[B_ACC] = 1'b1;
    if (set_dirty) upd_o[B_DIRTY] = 1'b1;
  end

  assign wb_o = present_o & (upd_o != entry_i);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int PA_W  = 52,
  parameter int VA_W  = 64,
  parameter int LVL_N = 5,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int LVL_W = $clog2(LVL_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic             five_lvl_i,
  input  logic [PFN_W-1:0] root_pfn_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [ENT_W-1:0] mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [ENT_W-1:0] mem_rdata_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic [1:0]       rsp_fault_o,
  output logic [2:0]       rsp_level_o,
  output logic [2:0]       rsp_perm_o
);
  st_e              st_q;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic             user_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PFN_W-1:0] base_q, nxt_q;
  perm_t            perm_q;
  logic [ENT_W-1:0] entry_q;
  logic [PA_W-1:0]  pa_q;
  flt_e             fault_q;

  logic             canon_ok;
  logic [IDX_W-1:0] idx;
  logic             leaf;
  logic             e_present, e_prot, e_wb;
  perm_t            e_perm;
  logic [ENT_W-1:0] e_upd;
  logic [PFN_W-1:0] e_pfn;

  ptw_canon #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_canon (
    .va_i   (req_va_i),
    .five_i (five_lvl_i),
    .ok_o   (canon_ok)
  );

  ptw_index #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LVL_N(LVL_N), .LVL_W(LVL_W)) u_idx (
    .va_i  (va_q),
    .lvl_i (lvl_q),
    .idx_o (idx)
  );

  assign leaf  = (lvl_q == LVL_W'(1));
  assign e_pfn = mem_rdata_i[OFF_W +: PFN_W];

  ptw_eval u_eval (
    .entry_i   (mem_rdata_i),
    .leaf_i    (leaf),
    .acc_i     (acc_q),
    .user_i    (user_q),
    .perm_i    (perm_q),
    .present_o (e_present),
    .perm_o    (e_perm),
    .prot_o    (e_prot),
    .upd_o     (e_upd),
    .wb_o      (e_wb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      va_q    <= '0;
      acc_q   <= ACC_LOAD;
      user_q  <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      nxt_q   <= '0;
      perm_q  <= '0;
      entry_q <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_va_i;
            acc_q   <= acc_e'(req_acc_i);
            user_q  <= req_user_i;
            perm_q  <= '{nx: 1'b0, user: 1'b1, wr: 1'b1};
            base_q  <= root_pfn_i;
            lvl_q   <= five_lvl_i ? LVL_W'(5) : LVL_W'(4);
            pa_q    <= '0;
            fault_q <= canon_ok ? FLT_NONE : FLT_CANON;
            st_q    <= canon_ok ? S_RD : S_RSP;
          end
        end
        S_RD: begin
          if (mem_ack_i) begin
            if (!e_present) begin
              fault_q <= FLT_NP;
              st_q    <= S_RSP;
            end else begin
              perm_q  <= e_perm;
              entry_q <= e_upd;
              nxt_q   <= e_pfn;
              if (leaf) begin
                fault_q <= e_prot ? FLT_PROT : FLT_NONE;
                if (!e_prot) pa_q <= {e_pfn, va_q[OFF_W-1:0]};
              end
              if (e_wb) begin
                st_q <= S_WB;
              end else if (leaf) begin
                st_q <= S_RSP;
              end else begin
                lvl_q  <= lvl_q - LVL_W'(1);
                base_q <= e_pfn;
              end
            end
          end
        end
        S_WB: begin
          if (mem_ack_i) begin
            if (leaf) begin
              st_q <= S_RSP;
            end else begin
              lvl_q  <= lvl_q - LVL_W'(1);
              base_q <= nxt_q;
              st_q   <= S_RD;
            end
          end
        end
        S_RSP: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign mem_req_o   = (st_q == S_RD) || (st_q == S_WB);
  assign mem_we_o    = (st_q == S_WB);
  assign mem_addr_o  = {base_q, idx, 3'b000};
  assign mem_wdata_o = entry_q;
  assign rsp_valid_o = (st_q == S_RSP);
  assign rsp_pa_o    = pa_q;
  assign rsp_fault_o = fault_q;
  assign rsp_level_o = 3'(lvl_q);
  assign rsp_perm_o  = (fault_q == FLT_NONE) ? perm_q : 3'b000;
endmodule

// File: rtl/ptw_top_chk.sv
module ptw_top_chk #(
  parameter int PA_W = 52
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic [63:0]     mem_wdata_o,
  input logic            mem_ack_i,
  input logic            rsp_valid_o,
  input logic [PA_W-1:0] rsp_pa_o,
  input logic [1:0]      rsp_fault_o,
  input logic [2:0]      rsp_level_o,
  input logic [2:0]      rsp_perm_o
);
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !rsp_valid_o);

  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_wb_same_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> $stable(mem_addr_o));

  assert_wb_accessed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && mem_wdata_o[5]);

  assert_fault_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o != 2'd0) |-> (rsp_pa_o == '0) && (rsp_perm_o == 3'd0));

  assert_canon_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o == 2'd3) |-> (rsp_level_o == 3'd4) || (rsp_level_o == 3'd5));

  assert_ok_leaf_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_fault_o == 2'd0) |-> rsp_level_o == 3'd1);
endmodule

bind ptw_top ptw_top_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_pa_o    (rsp_pa_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_level_o (rsp_level_o),
  .rsp_perm_o  (rsp_perm_o)
);

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        five = 1'b0;
  logic [39:0] root = '0;
  logic        busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata = '0;
  logic        rsp_valid;
  logic [51:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic [2:0]  rsp_level, rsp_perm;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_acc_i(req_acc), .req_user_i(req_user), .five_lvl_i(five), .root_pfn_i(root),
    .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault),
    .rsp_level_o(rsp_level), .rsp_perm_o(rsp_perm)
  );

  typedef struct {
    longint      a;
    bit          we;
    logic [63:0] d;
  } op_t;

  logic [63:0] mem [longint];
  op_t         expq [$];
  int          nchk = 0, nfail = 0;
  int          opn = 0, wcnt = 0;
  longint      next_frame = 64'h200;
  string       cur_req = "R2";

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input longint a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic longint idx_of(input logic [63:0] va, input int l);
    return longint'((va >> (12 + 9*(l-1))) & 64'h1ff);
  endfunction

  // memory responder, variable latency 0..2 extra cycles
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (rst_n && mem_req) begin
      if (wcnt >= (opn % 3)) begin
        op_t e;
        longint a;
        a = longint'(mem_addr);
        if (expq.size() == 0) begin
          chk(1'b0, cur_req, "unexpected memory access", {12'd0, mem_addr}, 64'd0);
        end else begin
          e = expq.pop_front();
          chk(a == e.a, cur_req, "entry address", a, e.a);
          chk(mem_we == e.we, cur_req, "access direction", {63'd0, mem_we}, {63'd0, e.we});
          if (e.we) chk(mem_wdata == e.d, "R6", "write-back data", mem_wdata, e.d);
        end
        if (mem_we) mem[a] = mem_wdata;
        else mem_rdata = rd(a);
        mem_ack = 1'b1;
        opn++;
      end else begin
        wcnt++;
      end
    end
  end

  // reference walk: fills expected access queue and returns the response
  task automatic model(input logic [63:0] va, input logic [1:0] acc, input bit user,
                       input bit f5, input longint rt,
                       output logic [51:0] pa, output logic [1:0] flt,
                       output logic [2:0] lvl, output logic [2:0] perm);
    int     nl, top;
    bit     wr, us, nx, lf, prot;
    longint base, a;
    logic [63:0] e, ne, hi;
    nl  = f5 ? 5 : 4;
    top = f5 ? 56 : 47;
    pa = '0; perm = '0; flt = 2'd0; lvl = 3'(nl);
    hi = va >> top;
    if (!((hi == 64'd0) || (hi == ({64{1'b1}} >> top)))) begin
      flt = 2'd3;
      return;
    end
    wr = 1; us = 1; nx = 0; base = rt;
    for (int l = nl; l >= 1; l--) begin
      a = base * 4096 + idx_of(va, l) * 8;
      e = rd(a);
      expq.push_back('{a: a, we: 1'b0, d: 64'd0});
      lvl = 3'(l);
      if (!e[0]) begin
        flt = 2'd1;
        return;
      end
      wr = wr & e[1]; us = us & e[2]; nx = nx | e[63];
      lf = (l == 1);
      prot = lf && ((acc == 2'd1 && !wr) || (user && !us) || (acc == 2'd2 && nx));
      ne = e | 64'h20;
      if (lf && acc == 2'd1 && !prot) ne = ne | 64'h40;
      if (ne != e) expq.push_back('{a: a, we: 1'b1, d: ne});
      base = longint'(e[51:12]);
      if (lf) begin
        if (prot) flt = 2'd2;
        else begin
          pa = {e[51:12], va[11:0]};
          perm = {nx, us, wr};
        end
      end
    end
  endtask

  task automatic map_va(input logic [63:0] va, input bit f5, input longint rt,
                        input logic [63:0] ifl, input logic [63:0] lfl, input longint pfn);
    longint base, a;
    base = rt;
    for (int l = (f5 ? 5 : 4); l >= 2; l--) begin
      a = base * 4096 + idx_of(va, l) * 8;
      if (!rd(a)[0]) begin
        mem[a] = (64'(next_frame) << 12) | ifl;
        next_frame++;
      end
      base = longint'(mem[a][51:12]);
    end
    a = base * 4096 + idx_of(va, 1) * 8;
    mem[a] = (64'(pfn) << 12) | lfl;
  endtask

  function automatic longint ent_addr(input logic [63:0] va, input longint rt, input int lv);
    longint base;
    base = rt;
    for (int l = 4; l > lv; l--) base = longint'(rd(base * 4096 + idx_of(va, l) * 8)[51:12]);
    return base * 4096 + idx_of(va, lv) * 8;
  endfunction

  task automatic walk(input string rq, input logic [63:0] va, input logic [1:0] acc,
                      input bit user, input bit f5, input longint rt, input bit hold);
    logic [51:0] epa;
    logic [1:0]  eflt;
    logic [2:0]  elvl, eperm;
    int          cyc;
    cur_req = rq;
    model(va, acc, user, f5, rt, epa, eflt, elvl, eperm);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc; req_user = user; five = f5; root = 40'(rt);
    @(negedge clk);
    if (hold) begin
      req_va = va ^ 64'h0000_0080_0000_0000; req_acc = 2'd1;
    end else begin
      req_valid = 1'b0;
    end
    cyc = 1;
    while (!rsp_valid) begin
      if (!busy) chk(1'b0, "R8", "busy during walk", 64'd0, 64'd1);
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8", "busy in response cycle", {63'd0, busy}, 64'd1);
    chk(rsp_fault == eflt, rq, "fault code", {62'd0, rsp_fault}, {62'd0, eflt});
    chk(rsp_level == elvl, rq, "level", {61'd0, rsp_level}, {61'd0, elvl});
    chk(rsp_pa == epa, rq, "physical address", {12'd0, rsp_pa}, {12'd0, epa});
    chk(rsp_perm == eperm, rq, "permissions", {61'd0, rsp_perm}, {61'd0, eperm});
    chk(expq.size() == 0, rq, "missing memory accesses", 64'(expq.size()), 64'd0);
    expq.delete();
    if (eflt == 2'd3) chk(cyc == 1, "R7", "canonical fault latency", 64'(cyc), 64'd1);
    @(negedge clk);
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R8", "idle after response",
        {62'd0, busy, rsp_valid}, 64'd0);
  endtask

  localparam longint ROOT4 = 64'h100;
  localparam longint ROOT5 = 64'h180;
  localparam logic [63:0] VA_A = 64'h0000_0012_3456_7abc;
  localparam logic [63:0] VA_B = 64'h0000_0012_3476_7abc;
  localparam logic [63:0] VA_C = 64'h0000_0080_0000_1000;
  localparam logic [63:0] VA_D = 64'h0000_0100_0000_2468;
  localparam logic [63:0] VA_E = 64'h0000_0180_0000_3fff;
  localparam logic [63:0] VA_F = 64'h0000_7f80_0000_0000;
  localparam logic [63:0] VA_G = 64'h0000_8000_0000_0000;
  localparam logic [63:0] VA_H = 64'hffff_8000_0040_5123;
  localparam logic [63:0] VA_5 = 64'h0012_3400_0000_4567;
  localparam logic [63:0] VA_N = 64'h0100_0000_0000_0000;

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    map_va(VA_A, 0, ROOT4, 64'h7, 64'h7, 64'hA_BCDE);
    map_va(VA_B, 0, ROOT4, 64'h7, 64'h7, 64'h1234);
    mem[ent_addr(VA_B, ROOT4, 2)] = 64'd0;
    map_va(VA_C, 0, ROOT4, 64'h7, 64'h5, 64'h2222);
    map_va(VA_D, 0, ROOT4, 64'h3, 64'h7, 64'h3333);
    map_va(VA_E, 0, ROOT4, 64'h7, 64'h8000_0000_0000_0007, 64'h4444);
    map_va(VA_H, 0, ROOT4, 64'h7, 64'h7, 64'hF_0001);
    map_va(VA_5, 1, ROOT5, 64'h7, 64'h7, 64'h5555);

    repeat (3) @(negedge clk);
    chk(busy == 0 && mem_req == 0 && rsp_valid == 0, "R9", "reset outputs",
        {61'd0, busy, mem_req, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0 && rsp_valid == 0, "R9", "idle after reset",
        {61'd0, busy, mem_req, rsp_valid}, 64'd0);

    walk("R1", VA_A, 2'd0, 1, 0, ROOT4, 0); // cold: accessed bits written
    walk("R6", VA_A, 2'd0, 1, 0, ROOT4, 0); // warm: no write-backs
    walk("R6", VA_A, 2'd1, 1, 0, ROOT4, 0); // store: leaf dirty
    walk("R2", VA_A, 2'd2, 0, 0, ROOT4, 0);
    walk("R5", VA_C, 2'd1, 1, 0, ROOT4, 0); // store to read-only
    walk("R5", VA_C, 2'd0, 1, 0, ROOT4, 0);
    walk("R5", VA_D, 2'd0, 1, 0, ROOT4, 0); // user on supervisor path
    walk("R5", VA_D, 2'd1, 0, 0, ROOT4, 0);
    walk("R5", VA_E, 2'd2, 0, 0, ROOT4, 0); // fetch from no-execute
    walk("R5", VA_E, 2'd0, 1, 0, ROOT4, 0);
    walk("R4", VA_B, 2'd0, 1, 0, ROOT4, 0); // missing at level 2
    walk("R4", VA_F, 2'd0, 1, 0, ROOT4, 0); // missing at root
    walk("R7", VA_G, 2'd0, 1, 0, ROOT4, 0);
    walk("R2", VA_H, 2'd1, 1, 0, ROOT4, 0);
    walk("R3", VA_5, 2'd1, 1, 1, ROOT5, 0);
    walk("R7", VA_5, 2'd0, 1, 0, ROOT4, 0);
    walk("R7", VA_N, 2'd0, 1, 1, ROOT5, 0);
    walk("R8", VA_A, 2'd0, 1, 0, ROOT4, 1); // held request while busy ignored
    chk(rd(ent_addr(VA_C, ROOT4, 1))[6] == 1'b0, "R6", "no dirty on faulted store",
        {63'd0, rd(ent_addr(VA_C, ROOT4, 1))[6]}, 64'd0);

    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule